// File: doc/BRIEF.md
# 16-bit Accumulator Arithmetic Unit

This unit carries out the word and byte arithmetic group of a small 8-bit controller core. A sequencer hands it a command made of an opcode, a 16-bit accumulator value, a 16-bit operand, and the present zero (Z), auxiliary-carry (AC) and carry (CY) flags. The unit returns the result, a write-back enable and the next values of all three flags. The operations are:

- word add, word subtract and word compare against the accumulator;
- 16-bit increment and decrement of a register pair;
- 8-bit increment and decrement of a byte register.

Each operation takes a fixed number of clocks. The unit reports that count as soon as the opcode is presented, so the sequencer can plan its stall. It then holds `busy` for exactly that many cycles and pulses `done` on the last one. Every operation has its own flag policy. A flag that the operation does not update is returned equal to the flag input sampled with the command, so the sequencer can always load all three outputs.

Top module: `wordop_unit`

## Requirements
- R1: Opcode 0 (word add) gives result = acc_in + opd_in mod 2^16 and drives wr_en. CY is the carry out of bit 15, AC is the carry out of bit 3, and Z is set when the 16-bit result is zero.
- R2: Opcode 1 (word subtract) gives result = acc_in - opd_in mod 2^16 and drives wr_en. CY is the borrow out of bit 15 (acc_in < opd_in), AC is the borrow out of bit 3 (acc_in[3:0] < opd_in[3:0]), and Z is set when the difference is zero.
- R3: Opcode 2 (word compare) sets Z, AC and CY exactly as R2 does, and result shows the difference. wr_en stays low.
- R4: Opcodes 3 and 4 (16-bit increment and decrement) give result = opd_in + 1 or opd_in - 1 mod 2^16 and drive wr_en. All three flag outputs equal z_in, ac_in and cy_in as sampled with the command.
- R5: Opcodes 5 and 6 (byte increment and decrement) give result[7:0] = opd_in[7:0] + 1 or opd_in[7:0] - 1 mod 256, with result[15:8] zero, and drive wr_en. Z is set when the byte result is zero. AC is the carry or borrow out of bit 3. CY equals cy_in as sampled with the command.
- R6: cmd_lat reports the clock count of the opcode on cmd_op, combinationally: 6 for opcodes 0 to 2, 4 for opcodes 3 and 4, 2 for opcodes 5 and 6, and 0 for the reserved opcode 7.
- R7: A command is accepted on a clock edge where cmd_valid is high, busy is low and the opcode is not reserved. After that edge, busy is high for exactly cmd_lat cycles and done is high only in the last of them. Result and flags are valid in the done cycle and are held until the next acceptance.
- R8: A command presented while busy is high has no effect on the running operation or its results. An opcode-7 command is never accepted, and busy stays low.
- R9: After a synchronous active-low reset, busy, done and wr_en are low, and result and all flag outputs are zero.
- R10: wr_en is high only in a done cycle of an operation that writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode (0 add, 1 sub, 2 cmp, 3 inc16, 4 dec16, 5 inc8, 6 dec8, 7 reserved) |
| acc_in | input | 16 | Accumulator pair value |
| opd_in | input | 16 | Immediate, register-pair or byte operand (byte in bits 7:0) |
| z_in | input | 1 | Current zero flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| cy_in | input | 1 | Current carry flag |
| cmd_lat | output | 3 | Clock count of the opcode on cmd_op |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last clock of the operation |
| wr_en | output | 1 | Result must be written back (only with done) |
| result | output | 16 | Operation result |
| flag_z | output | 1 | Next zero flag |
| flag_ac | output | 1 | Next auxiliary-carry flag |
| flag_cy | output | 1 | Next carry flag |

## Verification
The word operations are swept over a grid of sixteen boundary operands on both sides: zero, one, the nibble edges, the byte edges, the sign edge and all-ones. These pairs separate carry from borrow, carry out of bit 3 from carry out of bit 15, and a zero result that comes from wrap-around from one that comes from equal operands. The byte step operations are run over all 256 byte values with the upper operand byte filled with noise, which shows whether the unit tests only the low byte and clears the high byte. The flag inputs are toggled between commands, so any flag that should pass through unchanged but is recomputed shows up. A stray command is issued during some busy windows to show it is ignored.

// File: rtl/wordop_pkg.sv
// Package wordop_pkg
// Opcode encoding and per-operation control bundle shared by the
// arithmetic unit and its submodules. Assumes a 3-bit opcode field.
package wordop_pkg;

    typedef enum logic [2:0] {
        OP_ADDW = 3'd0,
        OP_SUBW = 3'd1,
        OP_CMPW = 3'd2,
        OP_INCW = 3'd3,
        OP_DECW = 3'd4,
        OP_INCB = 3'd5,
        OP_DECB = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    // Decoded control for one operation
    typedef struct packed {
        logic valid;     // opcode is executable
        logic a_is_acc;  // first adder input is the accumulator
        logic b_is_one;  // second adder input is the constant one
        logic sub;       // subtract instead of add
        logic byte_op;   // 8-bit operation
        logic wr;        // result is written back
        logic upd_z;     // zero flag recomputed
        logic upd_ac;    // aux-carry flag recomputed
        logic upd_cy;    // carry flag recomputed
    } ctl_t;

endpackage

// File: rtl/wordop_decode.sv
// Module wordop_decode
// Turns an opcode into the datapath control bundle and the fixed clock
// count of the operation. Purely combinational. Reserved codes decode to
// an invalid bundle with a zero count.
module wordop_decode
    import wordop_pkg::*;
#(
    parameter int LAT_W    = 3,
    parameter int LAT_WORD = 6,
    parameter int LAT_STEP = 4,
    parameter int LAT_BYTE = 2
) (
    input  logic [2:0]       op,
    output ctl_t             ctl,
    output logic [LAT_W-1:0] lat
);

    // Opcode to control and latency
    always_comb begin
        ctl = '0;
        lat = '0;
        case (op)
            OP_ADDW, OP_SUBW, OP_CMPW: begin
                ctl.valid    = 1'b1;
                ctl.a_is_acc = 1'b1;
                ctl.sub      = (op != OP_ADDW);
                ctl.wr       = (op != OP_CMPW);
                ctl.upd_z    = 1'b1;
                ctl.upd_ac   = 1'b1;
                ctl.upd_cy   = 1'b1;
                lat          = LAT_W'(LAT_WORD);
            end
            OP_INCW, OP_DECW: begin
                ctl.valid    = 1'b1;
                ctl.b_is_one = 1'b1;
                ctl.sub      = (op == OP_DECW);
                ctl.wr       = 1'b1;
                lat          = LAT_W'(LAT_STEP);
            end
            OP_INCB, OP_DECB: begin
                ctl.valid    = 1'b1;
                ctl.b_is_one = 1'b1;
                ctl.sub      = (op == OP_DECB);
                ctl.byte_op  = 1'b1;
                ctl.wr       = 1'b1;
                ctl.upd_z    = 1'b1;
                ctl.upd_ac   = 1'b1;
                lat          = LAT_W'(LAT_BYTE);
            end
            default: begin
                ctl = '0;
                lat = '0;
            end
        endcase
    end

endmodule

// File: rtl/wordop_addsub.sv
// Module wordop_addsub
// Shared W-bit adder/subtractor. Reports the carry (add) or the borrow
// (subtract) out of the top bit and out of bit AUX-1. Subtraction is
// done as a + ~b + 1; the borrow is the inverted carry.
module wordop_addsub #(
    parameter int W   = 16,
    parameter int AUX = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cy,
    output logic         ac
);

    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic [AUX:0] low;

    // Conditional operand inversion
    always_comb b_eff = sub ? ~b : b;

    // Full-width sum with carry in for subtract
    always_comb full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    // Low-nibble sum giving the auxiliary carry
    always_comb low = {1'b0, a[AUX-1:0]} + {1'b0, b_eff[AUX-1:0]} + {{AUX{1'b0}}, sub};

    // Carry outputs, turned into borrows for subtract
    always_comb begin
        sum = full[W-1:0];
        cy  = full[W] ^ sub;
        ac  = low[AUX] ^ sub;
    end

endmodule

// File: rtl/wordop_flagmerge.sv
// Module wordop_flagmerge
// Forms the final result (byte results zero-extended) and merges the
// computed flags with the incoming ones according to the update policy.
module wordop_flagmerge #(
    parameter int W  = 16,
    parameter int BW = 8
) (
    input  logic [W-1:0] sum,
    input  logic         cy_raw,
    input  logic         ac_raw,
    input  logic         byte_op,
    input  logic         upd_z,
    input  logic         upd_ac,
    input  logic         upd_cy,
    input  logic         z_in,
    input  logic         ac_in,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         z_nx,
    output logic         ac_nx,
    output logic         cy_nx
);

    logic z_calc;

    // Width selection of the result
    always_comb res = byte_op ? {{(W-BW){1'b0}}, sum[BW-1:0]} : sum;

    // Zero test over the selected width
    always_comb z_calc = (res == '0);

    // Per-flag keep-or-update choice
    always_comb begin
        z_nx  = upd_z  ? z_calc : z_in;
        ac_nx = upd_ac ? ac_raw : ac_in;
        cy_nx = upd_cy ? cy_raw : cy_in;
    end

endmodule

// File: rtl/wordop_seq.sv
// Module wordop_seq
// Countdown sequencer. start loads the operation latency. busy is high
// while the count is non-zero and done marks the count of one (the last
// cycle). Assumes start is only raised while idle and lat >= 1.
module wordop_seq #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             busy,
    output logic             done
);

    logic [LAT_W-1:0] cnt;

    // Remaining-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= lat;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Status decode
    always_comb begin
        busy = (cnt != '0);
        done = (cnt == LAT_W'(1));
    end

endmodule

// File: rtl/wordop_unit.sv
// Module wordop_unit
// Word/byte arithmetic unit of a small controller core. A command is
// accepted when valid, idle and not reserved; the result and the flags
// are computed from the inputs at the accepting edge and held in
// registers. The sequencer then stretches the operation to its fixed
// clock count. Assumes the caller keeps track of the flags and writes
// back the result when wr_en is high.
module wordop_unit
    import wordop_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int AUX_BIT  = 4,
    parameter int LAT_WORD = 6,
    parameter int LAT_STEP = 4,
    parameter int LAT_BYTE = 2,
    localparam int BYTE_W  = DATA_W / 2,
    localparam int LAT_MAX = (LAT_WORD > LAT_STEP)
                           ? ((LAT_WORD > LAT_BYTE) ? LAT_WORD : LAT_BYTE)
                           : ((LAT_STEP > LAT_BYTE) ? LAT_STEP : LAT_BYTE),
    localparam int LAT_W   = $clog2(LAT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opd_in,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic [LAT_W-1:0]  cmd_lat,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_ac,
    output logic              flag_cy
);

    ctl_t              ctl;
    logic              accept;
    logic [DATA_W-1:0] a_op;
    logic [DATA_W-1:0] b_op;
    logic [DATA_W-1:0] sum;
    logic              cy_raw;
    logic              ac_raw;
    logic [DATA_W-1:0] res_nx;
    logic              z_nx;
    logic              ac_nx;
    logic              cy_nx;
    logic [DATA_W-1:0] res_q;
    logic              z_q;
    logic              ac_q;
    logic              cy_q;
    logic              wr_q;

    wordop_decode #(
        .LAT_W    (LAT_W),
        .LAT_WORD (LAT_WORD),
        .LAT_STEP (LAT_STEP),
        .LAT_BYTE (LAT_BYTE)
    ) decode_i (
        .op  (cmd_op),
        .ctl (ctl),
        .lat (cmd_lat)
    );

    // Command acceptance
    always_comb accept = cmd_valid && !busy && ctl.valid;

    // Adder operand selection
    always_comb begin
        a_op = ctl.a_is_acc ? acc_in : opd_in;
        b_op = ctl.b_is_one ? DATA_W'(1) : opd_in;
    end

    wordop_addsub #(
        .W   (DATA_W),
        .AUX (AUX_BIT)
    ) addsub_i (
        .a   (a_op),
        .b   (b_op),
        .sub (ctl.sub),
        .sum (sum),
        .cy  (cy_raw),
        .ac  (ac_raw)
    );

    wordop_flagmerge #(
        .W  (DATA_W),
        .BW (BYTE_W)
    ) flags_i (
        .sum     (sum),
        .cy_raw  (cy_raw),
        .ac_raw  (ac_raw),
        .byte_op (ctl.byte_op),
        .upd_z   (ctl.upd_z),
        .upd_ac  (ctl.upd_ac),
        .upd_cy  (ctl.upd_cy),
        .z_in    (z_in),
        .ac_in   (ac_in),
        .cy_in   (cy_in),
        .res     (res_nx),
        .z_nx    (z_nx),
        .ac_nx   (ac_nx),
        .cy_nx   (cy_nx)
    );

    wordop_seq #(
        .LAT_W (LAT_W)
    ) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .lat   (cmd_lat),
        .busy  (busy),
        .done  (done)
    );

    // Result and flag capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            z_q   <= 1'b0;
            ac_q  <= 1'b0;
            cy_q  <= 1'b0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            res_q <= res_nx;
            z_q   <= z_nx;
            ac_q  <= ac_nx;
            cy_q  <= cy_nx;
            wr_q  <= ctl.wr;
        end
    end

    // Output drive
    always_comb begin
        result  = res_q;
        flag_z  = z_q;
        flag_ac = ac_q;
        flag_cy = cy_q;
        wr_en   = done && wr_q;
    end

endmodule

// File: rtl/wordop_unit_chk.sv
// Module wordop_unit_chk
// Property checker for wordop_unit, bound to every instance. It keeps its
// own copy of the accepted opcode and latency and counts busy cycles.
module wordop_unit_chk
    import wordop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              z_in,
    input logic              ac_in,
    input logic              cy_in,
    input logic [LAT_W-1:0]  cmd_lat,
    input logic              busy,
    input logic              done,
    input logic              wr_en,
    input logic [DATA_W-1:0] result,
    input logic              flag_z,
    input logic              flag_ac,
    input logic              flag_cy
);

    localparam int BW = DATA_W / 2;

    logic             acc_seen;
    logic [2:0]       op_q;
    logic [LAT_W-1:0] lat_q;
    logic [LAT_W-1:0] elapsed;

    // Acceptance as seen from the ports
    always_comb acc_seen = cmd_valid && !busy && (cmd_lat != '0);

    // Track accepted opcode, latency and elapsed busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= 3'd0;
            lat_q   <= '0;
            elapsed <= '0;
        end else if (acc_seen) begin
            op_q    <= cmd_op;
            lat_q   <= cmd_lat;
            elapsed <= LAT_W'(1);
        end else if (busy) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R7
    done_at_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && elapsed == lat_q));

    // R7
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_seen |=> busy);

    // R8
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(result) && $stable(flag_z) && $stable(flag_ac) && $stable(flag_cy)));

    // R8
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op == OP_RSVD) |=> !busy);

    // R10
    wr_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && op_q != OP_CMPW));

    // R3
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_CMPW) |-> !wr_en);

    // R4
    step16_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_seen && (cmd_op == OP_INCW || cmd_op == OP_DECW))
        |=> ({flag_z, flag_ac, flag_cy} == $past({z_in, ac_in, cy_in})));

    // R5
    byte_cy_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_seen && (cmd_op == OP_INCB || cmd_op == OP_DECB))
        |=> (flag_cy == $past(cy_in)));

    // R5
    byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_INCB || op_q == OP_DECB))
        |-> (result[DATA_W-1:BW] == '0 && flag_z == (result[BW-1:0] == '0)));

    // R1
    word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_ADDW || op_q == OP_SUBW || op_q == OP_CMPW))
        |-> (flag_z == (result == '0)));

endmodule

bind wordop_unit wordop_unit_chk #(
    .DATA_W (DATA_W),
    .LAT_W  (LAT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .z_in      (z_in),
    .ac_in     (ac_in),
    .cy_in     (cy_in),
    .cmd_lat   (cmd_lat),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .result    (result),
    .flag_z    (flag_z),
    .flag_ac   (flag_ac),
    .flag_cy   (flag_cy)
);

// File: tb/wordop_unit_tb_top.sv
// Bench for wordop_unit: sweeps of the word operations over boundary
// operands and exhaustive sweeps of the byte steps; all expected values
// are computed arithmetically here.
module wordop_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] acc_in = 16'h0;
    logic [15:0] opd_in = 16'h0;
    logic        z_in = 1'b0;
    logic        ac_in = 1'b0;
    logic        cy_in = 1'b0;
    logic [2:0]  cmd_lat;
    logic        busy;
    logic        done;
    logic        wr_en;
    logic [15:0] result;
    logic        flag_z;
    logic        flag_ac;
    logic        flag_cy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wordop_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .acc_in    (acc_in),
        .opd_in    (opd_in),
        .z_in      (z_in),
        .ac_in     (ac_in),
        .cy_in     (cy_in),
        .cmd_lat   (cmd_lat),
        .busy      (busy),
        .done      (done),
        .wr_en     (wr_en),
        .result    (result),
        .flag_z    (flag_z),
        .flag_ac   (flag_ac),
        .flag_cy   (flag_cy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] grid(input int i);
        case (i)
            0:  return 16'h0000;
            1:  return 16'h0001;
            2:  return 16'h0008;
            3:  return 16'h000F;
            4:  return 16'h0010;
            5:  return 16'h00FF;
            6:  return 16'h0100;
            7:  return 16'h0FFF;
            8:  return 16'h1234;
            9:  return 16'h7FFF;
            10: return 16'h8000;
            11: return 16'h8001;
            12: return 16'hA5C3;
            13: return 16'hFFF0;
            14: return 16'hFFFE;
            default: return 16'hFFFF;
        endcase
    endfunction

    // Expected outputs from the requirements
    task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic zi, input logic aci, input logic cyi,
                         output logic [15:0] r, output logic z, output logic ac,
                         output logic cy, output logic wr, output int lat);
        logic [16:0] s;
        logic [8:0]  sb;
        r = 16'h0; z = zi; ac = aci; cy = cyi; wr = 1'b1; lat = 0;
        case (op)
            3'd0: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[15:0]; cy = s[16];
                ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
                z = (r == 16'h0); lat = 6;
            end
            3'd1, 3'd2: begin
                r = a - b; cy = (a < b); ac = (a[3:0] < b[3:0]);
                z = (r == 16'h0); lat = 6; wr = (op == 3'd1);
            end
            3'd3: begin r = b + 16'd1; lat = 4; end
            3'd4: begin r = b - 16'd1; lat = 4; end
            3'd5, 3'd6: begin
                sb = (op == 3'd5) ? ({1'b0, b[7:0]} + 9'd1) : ({1'b0, b[7:0]} - 9'd1);
                r = {8'h00, sb[7:0]};
                z = (sb[7:0] == 8'h00);
                ac = (op == 3'd5) ? (b[3:0] == 4'hF) : (b[3:0] == 4'h0);
                lat = 2;
            end
            default: begin wr = 1'b0; lat = 0; end
        endcase
    endtask

    // Issue one command and check it through to the cycle after done
    task automatic run_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                          input logic [2:0] fl, input bit stray, input string req);
        logic [15:0] er;
        logic ez, eac, ecy, ewr;
        int el;
        bit tim_ok;
        model(op, a, b, fl[2], fl[1], fl[0], er, ez, eac, ecy, ewr, el);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; acc_in = a; opd_in = b;
        {z_in, ac_in, cy_in} = fl;
        #0.5;
        check(cmd_lat == 3'(el), "R6", "latency report", 32'(cmd_lat), 32'(el));
        @(negedge clk);
        if (stray) begin
            // R8: stray command during busy
            cmd_op = (op == 3'd0) ? 3'd1 : 3'd0;
            acc_in = ~a; opd_in = b ^ 16'h5A5A; {z_in, ac_in, cy_in} = ~fl;
        end else begin
            cmd_valid = 1'b0;
        end
        tim_ok = 1'b1;
        for (int k = 1; k <= el; k++) begin
            if (k > 1) @(negedge clk);
            if (!busy || (done != (k == el))) tim_ok = 1'b0;
            if (k == el) begin
                cmd_valid = 1'b0;
                check(result == er, req, "result", 32'(result), 32'(er));
                check({flag_z, flag_ac, flag_cy} == {ez, eac, ecy}, req, "flags Z/AC/CY",
                      32'({flag_z, flag_ac, flag_cy}), 32'({ez, eac, ecy}));
                check(wr_en == ewr, (op == 3'd2) ? "R3" : "R10", "write enable",
                      32'(wr_en), 32'(ewr));
            end
        end
        check(tim_ok, "R7", "busy/done window", 32'(tim_ok), 32'd1);
        @(negedge clk);
        check(!busy && !done && !wr_en && result == er, stray ? "R8" : "R7",
              "idle and held after done", {busy, done, wr_en, 13'h0, result}, {16'h0, er});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!busy && !done && !wr_en && result == 16'h0 && !flag_z && !flag_ac && !flag_cy,
              "R9", "reset state", {busy, done, wr_en, flag_z, flag_ac, flag_cy, 10'h0, result}, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3 word operations over a boundary grid
        for (int op = 0; op < 3; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_op(3'(op), grid(i), grid(j), 3'((i + j + op) % 8),
                           ((i * 16 + j) % 37) == 5,
                           (op == 0) ? "R1" : (op == 1) ? "R2" : "R3");
                end
            end
        end

        // R4 16-bit step operations
        for (int op = 3; op < 5; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int f = 0; f < 8; f++) begin
                    run_op(3'(op), grid(15 - i), grid(i), 3'(f), f == 3, "R4");
                end
            end
        end

        // R5 byte step operations over every byte value
        for (int op = 5; op < 7; op++) begin
            for (int v = 0; v < 256; v++) begin
                run_op(3'(op), 16'hBEEF, {8'(v * 7 + 3), 8'(v)}, 3'(v % 8), (v % 29) == 0, "R5");
            end
        end

        // R8 reserved opcode is not accepted
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd7; acc_in = 16'h1111; opd_in = 16'h2222;
        #0.5;
        check(cmd_lat == 3'd0, "R6", "reserved latency", 32'(cmd_lat), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!busy && !done, "R8", "reserved opcode ignored", {busy, done}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule